// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Bridge

The bridge lets a processor fetch code and constants straight out of an external serial flash by issuing ordinary reads inside a fixed address window. Each accepted bus read becomes one complete single-lane SPI transaction. The transaction sends the read opcode 03h, then a 24-bit flash address, and then clocks in 1, 2, 4 or 8 data bytes. There are no dummy cycles between the address and the data.

The bus side has a one-deep request/done handshake. A request is taken only while the bridge is idle. Completion is signalled by a single-cycle done pulse, and the assembled little-endian data is valid in that same cycle. The serial clock is derived from the system clock by an even division ratio. The bridge also enforces chip-select setup, hold and deselect spacing around every transaction.

Top module: `spi_flash_reader`

## Requirements
- R1: Every accepted request opens a transaction whose first 8 bits on `spi_mosi`, sent MSB first, are the opcode 03h.
- R2: The 24 bits that directly follow the opcode are the flash address, sent MSB first. The flash address is `req_addr - BASE_ADDR` (default 0x1800_0000) truncated to 24 bits, so it wraps modulo 2^24.
- R3: No dummy bits are inserted. The first data bit is the one sampled on the 33rd rising serial-clock edge.
- R4: The number of data bits equals the access size. `req_size` 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes, giving exactly 32 + 8·bytes rising edges per transaction.
- R5: Data bytes arrive MSB first. The byte at the lowest flash address is placed in `rsp_data[7:0]`, the next in `[15:8]`, and so on. Bits above the requested size read as zero.
- R6: SPI mode 0. `spi_sck` is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sck` is low, and `spi_miso` is sampled on the rising edge.
- R7: The serial-clock period is exactly `CLK_DIV` system clocks. `CLK_DIV` must be even and at least 2.
- R8: `spi_cs_n` falls at least one system clock before the first rising edge. It rises no sooner than one serial-clock period after the last rising edge, and it then stays high for at least `DESEL_CYCLES` system clocks before it can fall again.
- R9: `req_ready` is high only while idle. A `req_valid` presented while busy is ignored and starts no transaction.
- R10: `rsp_valid` is high for exactly one system clock per transaction, with `rsp_data` valid in that cycle.
- R11: After reset the bridge is idle, with `spi_cs_n` high, `spi_sck` low, `req_ready` high and `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_addr | input | 32 | Bus byte address inside the flash window |
| req_size | input | 2 | Access size: 0=1, 1=2, 2=4, 3=8 bytes |
| req_ready | output | 1 | High when a request will be accepted |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | 64 | Little-endian read data, valid with rsp_valid |
| spi_cs_n | output | 1 | Active-low flash select |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
The bench builds the bridge with `CLK_DIV = 4` and `DESEL_CYCLES = 3`. With these values each serial half-period lasts two system clocks, so a change of `spi_mosi` during the high phase, a wrong period, or a short setup, hold or deselect gap shows up as a count that differs by at least one cycle. A small arithmetic flash model lets every access size be swept across addresses at the window base, in the middle of the window, at the 24-bit wrap point and beyond the window's top. Back-to-back requests and requests made while busy exercise the deselect spacing and the one-outstanding rule.

// File: rtl/spi_flash_reader.sv
module spi_flash_reader #(
  parameter int          CLK_DIV      = 4,
  parameter int          DESEL_CYCLES = 3,
  parameter logic [31:0] BASE_ADDR    = 32'h1800_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [63:0] rsp_data,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int TMAX = (CLK_DIV > DESEL_CYCLES) ? CLK_DIV : DESEL_CYCLES;
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {IDLE, SETUP, SHIFT, HOLD, GAP} state_t;

  state_t      state;
  logic [CW-1:0] cnt;
  logic [6:0]  bitn, nbits;
  logic [3:0]  nbytes;
  logic [31:0] tx;
  logic [63:0] rx, packed_le;
  logic [31:0] offs;

  assign offs      = req_addr - BASE_ADDR;
  assign req_ready = (state == IDLE);
  assign spi_mosi  = tx[31];

  always_comb begin
    packed_le = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(nbytes)) packed_le[8*i +: 8] = rx[8*(int'(nbytes) - 1 - i) +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      cnt       <= '0;
      bitn      <= '0;
      nbits     <= '0;
      nbytes    <= '0;
      tx        <= '0;
      rx        <= '0;
      spi_cs_n  <= 1'b1;
      spi_sck   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          tx       <= {8'h03, offs[23:0]};
          nbytes   <= 4'd1 << req_size;
          nbits    <= 7'd32 + (7'd8 << req_size);
          bitn     <= '0;
          cnt      <= '0;
          spi_cs_n <= 1'b0;
          state    <= SETUP;
        end
        SETUP: state <= SHIFT;
        SHIFT: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            if (!spi_sck) begin
              spi_sck <= 1'b1;
              rx      <= {rx[62:0], spi_miso};
            end else begin
              spi_sck <= 1'b0;
              tx      <= {tx[30:0], 1'b0};
              bitn    <= bitn + 7'd1;
              if (bitn == nbits - 7'd1) state <= HOLD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        HOLD: begin
          if (cnt == CW'(CLK_DIV - 1)) begin
            cnt       <= '0;
            spi_cs_n  <= 1'b1;
            rsp_valid <= 1'b1;
            rsp_data  <= packed_le;
            state     <= GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        GAP: begin
          if (cnt >= CW'(DESEL_CYCLES - 1)) begin
            cnt   <= '0;
            state <= IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

module spi_flash_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        spi_cs_n,
  input logic        spi_sck,
  input logic        spi_mosi
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !spi_sck); // R6
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (!spi_cs_n && spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R6
  AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $rose(spi_sck) |-> (!spi_cs_n && $past(!spi_cs_n))); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R10
  AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> spi_cs_n); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (spi_cs_n && !spi_sck)); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready); // R9
endmodule

bind spi_flash_reader spi_flash_reader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
);

// File: tb/spi_flash_reader_tb_top.sv
module spi_flash_reader_tb_top;
  localparam int CLK_DIV = 4;
  localparam int DESEL   = 3;
  localparam logic [31:0] BASE = 32'h1800_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic req_ready, rsp_valid, spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;
  logic [63:0] rsp_data;

  int checks = 0, fails = 0;
  always #2 clk = ~clk;

  spi_flash_reader #(.CLK_DIV(CLK_DIV), .DESEL_CYCLES(DESEL), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  function automatic logic [7:0] mem(input logic [23:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ (a[23:16] + 8'h5A);
  endfunction

  // flash model
  int bcnt = 0, txn = 0, last_bits = 0;
  logic in_txn = 1'b0;
  logic [31:0] hdr = '0, last_hdr = '0;
  always @(negedge spi_cs_n) begin bcnt = 0; hdr = '0; in_txn = 1'b1; end
  always @(posedge spi_sck) begin
    if (bcnt < 32) hdr = {hdr[30:0], spi_mosi};
    bcnt++;
  end
  always @(negedge spi_sck) begin
    if (bcnt >= 32) begin
      automatic int k = bcnt - 32;
      automatic logic [7:0] b = mem(hdr[23:0] + 24'(k / 8));
      spi_miso = b[7 - (k % 8)];
    end
  end
  always @(posedge spi_cs_n) if (in_txn) begin
    in_txn = 1'b0; txn++; last_hdr = hdr; last_bits = bcnt;
  end

  // timing monitor
  int err_r6 = 0, err_r7 = 0, err_r8 = 0, per = 0, gapc = 0;
  logic psck = 1'b0, pmosi = 1'b0, pcs = 1'b1, first_rise = 1'b0, ever_sel = 1'b0;
  always @(negedge clk) if (rst_n) begin
    per++;
    if (spi_cs_n && spi_sck) err_r6++;
    if (!spi_cs_n && spi_sck && psck && spi_mosi !== pmosi) err_r6++;
    if (pcs && !spi_cs_n) begin
      if (ever_sel && gapc < DESEL) err_r8++;
      ever_sel = 1'b1; per = 0; first_rise = 1'b1;
    end
    if (!pcs && spi_cs_n && per < CLK_DIV) err_r8++;
    if (spi_cs_n) gapc++; else gapc = 0;
    if (!spi_cs_n && spi_sck && !psck) begin
      if (first_rise) begin if (per < 2) err_r8++; end
      else if (per != CLK_DIV) err_r7++;
      first_rise = 1'b0; per = 0;
    end
    psck = spi_sck; pmosi = spi_mosi; pcs = spi_cs_n;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic do_read(input logic [31:0] addr, input logic [1:0] sz, input bit poke);
    automatic int nb = 1 << sz;
    automatic logic [23:0] fa = 24'(addr - BASE);
    automatic logic [63:0] exp = '0;
    automatic int t0;
    for (int i = 0; i < nb; i++) exp[8*i +: 8] = mem(fa + 24'(i));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    t0 = txn;
    req_valid = 1'b1; req_addr = addr; req_size = sz;
    @(negedge clk);
    if (poke) begin
      req_addr = addr ^ 32'h0000_5555; req_size = 2'd3;
      for (int i = 0; i < 6; i++) begin
        chk(!req_ready, "R9 ready while busy", {63'd0, req_ready}, 64'd0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_data === exp, "R5/R3 data", rsp_data, exp);
    chk(last_hdr[31:24] == 8'h03, "R1 opcode", {56'd0, last_hdr[31:24]}, 64'h03);
    chk(last_hdr[23:0] == fa, "R2 address", {40'd0, last_hdr[23:0]}, {40'd0, fa});
    chk(last_bits == 32 + 8 * nb, "R4 bit count", 64'(last_bits), 64'(32 + 8 * nb));
    chk(txn == t0 + 1, "R9 one transaction", 64'(txn - t0), 64'd1);
    @(negedge clk);
    chk(!rsp_valid, "R10 done width", {63'd0, rsp_valid}, 64'd0);
  endtask

  logic [31:0] addrs [6] = '{32'h1800_0000, 32'h1800_0001, 32'h1812_3456,
                             32'h18FF_FFFD, 32'h1900_0002, 32'h18A5_5A07};

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sck && !rsp_valid, "R11 reset outputs",
        {61'd0, spi_cs_n, spi_sck, rsp_valid}, 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R11 ready after reset", {63'd0, req_ready}, 64'd1);
    for (int a = 0; a < 6; a++)
      for (int s = 0; s < 4; s++)
        do_read(addrs[a], 2'(s), (a + s) % 3 == 0);
    for (int s = 0; s < 4; s++) begin
      fork
        do_read(BASE + 32'h40, 2'(s), 1'b0);
      join
    end
    chk(err_r6 == 0, "R6 mode 0 edges", 64'(err_r6), 64'd0);
    chk(err_r7 == 0, "R7 sck period", 64'(err_r7), 64'd0);
    chk(err_r8 == 0, "R8 select timing", 64'(err_r8), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule